// File: doc/BRIEF.md
# Power Button Supply Controller

This block decides when the main supply is switched on. There are three ways to ask for it: a press of the power button, a wake-up request and a software command. Each one starts a ramp phase. During the ramp the supply-enable output is already high and the block waits for a power-good confirmation. If the confirmation does not arrive within a programmable number of seconds (the crowbar limit), the block drops the supply again. Once the supply is confirmed it stays on until a button press or a software off command arrives.

All timing uses a one-cycle timebase tick, nominally 32.768 kHz. If the button is held for the override time, the supply is forced off no matter what else is pending. After that, the block accepts no request to turn on until the button has been released. The block also reports the button level back to the system, and it turns each sleep-button press into a single event pulse.

All inputs are plain control levels or pulses, and there is no data stream, so no port uses a valid/ready handshake.

Top module: `pbsc_supply_ctrl`

## Requirements
- R1: When the supply is off, a rising edge of `btn_i` raises `supply_on_o` on the next clock and starts the ramp phase.
- R2: A rising edge of `btn_i` during the ramp phase or the confirmed-on phase drops `supply_on_o` on the next clock.
- R3: Once `btn_i` has been high on `HOLD_TICKS` tick cycles in a row, the supply is forced off on the clock that counts the last tick. This takes priority over any wake, software or power-good input in the same cycle.
- R4: After a forced-off override, every on request (button edge, wake, software on) is ignored until `btn_i` has been sampled low. After the release, a new press turns the supply on as in R1.
- R5: When the supply is off, a high `wake_req_i` raises `supply_on_o` on the next clock.
- R6: `sw_on_i` behaves like an on request and `sw_off_i` like an off request. `sw_on_i` has no effect while the supply is on, and `sw_off_i` has no effect while it is off.
- R7: `pwr_ok_i` high during the ramp moves the block to the confirmed-on phase, after which the crowbar limit no longer applies. If the time-out and the confirmation fall in the same cycle, the confirmation wins.
- R8: While unconfirmed, the ramp ends and `supply_on_o` falls after `crowbar_sel_i` × `TICKS_PER_SEC` ticks. A `crowbar_sel_i` of 0 disables the time-out.
- R9: `pbtn_o` equals `btn_i` delayed by one clock.
- R10: Each rising edge of `sleep_btn_i` produces exactly one one-clock pulse on `sleep_evt_o`, on the clock after the edge is sampled.
- R11: While `rst_n` is low, and right after it is released, all outputs are low and the supply is off.
- R12: The override and crowbar timers advance only on clocks where `tick_i` is high. Holding the button with no ticks never forces the supply off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| btn_i | input | 1 | Debounced power button, high when pressed |
| sleep_btn_i | input | 1 | Debounced sleep button, high when pressed |
| wake_req_i | input | 1 | Wake-up request |
| sw_on_i | input | 1 | Software on command |
| sw_off_i | input | 1 | Software off command |
| pwr_ok_i | input | 1 | Supply confirmed good |
| crowbar_sel_i | input | CB_W | Crowbar limit in seconds, 0 = disabled |
| supply_on_o | output | 1 | Main supply enable |
| pbtn_o | output | 1 | Button level mirrored to the system |
| sleep_evt_o | output | 1 | One-clock sleep-button event |

## Verification
The assertions assume that the button inputs are already debounced and synchronous to `clk`, so that one press gives exactly one rising edge. They also assume that `crowbar_sel_i` stays stable for the whole ramp phase, and that `tick_i` is a clean pulse sampled on the same clock. The directed stimulus changes the crowbar limit only while the supply is off, and it holds the tick either always high or always low, so that the timer windows are exact. The random stimulus keeps the limit at zero and ends every button run before it reaches the override length. This keeps every cycle inside the phase logic that the bench predicts.

// File: rtl/pbsc_pkg.sv
package pbsc_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_RAMP = 2'd1,
    PS_ON   = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/pbsc_edge_reg.sv
// Registers a set of synchronous levels and flags their rising edges.
module pbsc_edge_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] rise_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/pbsc_hold_timer.sv
// Counts consecutive ticks with the button held. It fires once, then locks until release.
module pbsc_hold_timer #(
  parameter int HOLD_TICKS = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic btn_i,
  output logic fire_o,
  output logic lock_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          lock_q;

  assign fire_o = btn_i & tick_i & ~lock_q & (cnt_q == LAST);
  assign lock_o = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!btn_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q && tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        lock_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbsc_crowbar.sv
// Ramp time-out: a seconds prescaler plus a seconds counter, both cleared outside the ramp.
module pbsc_crowbar #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CB_W          = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic [CB_W-1:0] limit_i,
  output logic            expire_o
);
  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam logic [PW-1:0] P_LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0]   pre_q;
  logic [CB_W-1:0] sec_q;
  logic            sec_wrap;

  assign sec_wrap = tick_i & (pre_q == P_LAST);
  assign expire_o = run_i & (limit_i != '0) & sec_wrap
                  & (sec_q == (limit_i - CB_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (tick_i) begin
      if (sec_wrap) begin
        pre_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbsc_supply_ctrl.sv
module pbsc_supply_ctrl
  import pbsc_pkg::*;
#(
  parameter int HOLD_TICKS    = 131072,
  parameter int TICKS_PER_SEC = 32768,
  parameter int CB_W          = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            btn_i,
  input  logic            sleep_btn_i,
  input  logic            wake_req_i,
  input  logic            sw_on_i,
  input  logic            sw_off_i,
  input  logic            pwr_ok_i,
  input  logic [CB_W-1:0] crowbar_sel_i,
  output logic            supply_on_o,
  output logic            pbtn_o,
  output logic            sleep_evt_o
);
  localparam int BTN = 0;
  localparam int SLP = 1;

  pwr_state_t state_q, state_d;
  logic [1:0] lvl_q, rise;
  logic       ovr_fire, ovr_lock, cb_expire;
  logic       on_req, off_req;
  logic       sleep_evt_q;

  pbsc_edge_reg #(.W(2)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({sleep_btn_i, btn_i}),
    .lvl_q  (lvl_q),
    .rise_o (rise)
  );

  pbsc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .btn_i  (btn_i),
    .fire_o (ovr_fire),
    .lock_o (ovr_lock)
  );

  pbsc_crowbar #(.TICKS_PER_SEC(TICKS_PER_SEC), .CB_W(CB_W)) u_crowbar (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .run_i    (state_q == PS_RAMP),
    .limit_i  (crowbar_sel_i),
    .expire_o (cb_expire)
  );

  // After an override, nothing may turn the supply back on until the button is released.
  assign on_req  = ~ovr_lock & (rise[BTN] | wake_req_i | sw_on_i);
  assign off_req = rise[BTN] | sw_off_i;

  always_comb begin
    state_d = state_q;
    if (ovr_fire) begin
      state_d = PS_OFF;
    end else begin
      unique case (state_q)
        PS_OFF:  if (on_req) state_d = PS_RAMP;
        PS_RAMP: begin
          if (off_req)        state_d = PS_OFF;
          else if (pwr_ok_i)  state_d = PS_ON;
          else if (cb_expire) state_d = PS_OFF;
        end
        PS_ON:   if (off_req) state_d = PS_OFF;
        default: state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_OFF;
      sleep_evt_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      sleep_evt_q <= rise[SLP];
    end
  end

  assign supply_on_o = (state_q != PS_OFF);
  assign pbtn_o      = lvl_q[BTN];
  assign sleep_evt_o = sleep_evt_q;
endmodule

// File: rtl/pbsc_checker.sv
module pbsc_checker
  import pbsc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       btn_i,
  input logic       sw_off_i,
  input logic       pwr_ok_i,
  input logic       supply_on_o,
  input logic       pbtn_o,
  input logic       sleep_evt_o,
  input pwr_state_t st,
  input logic       fire,
  input logic       lock,
  input logic       expire
);
  a_r1_press_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_OFF && btn_i && !pbtn_o && !lock && !fire) |=> supply_on_o);

  a_r2_press_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PS_OFF && btn_i && !pbtn_o) |=> !supply_on_o);

  a_r3_override_off: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (st == PS_OFF));

  a_r4_lock_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !supply_on_o);

  a_r6_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ON && sw_off_i) |=> !supply_on_o);

  a_r7_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_RAMP && pwr_ok_i && !sw_off_i && !(btn_i && !pbtn_o) && !fire)
      |=> (st == PS_ON));

  a_r8_crowbar_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !pwr_ok_i) |=> !supply_on_o);

  a_r9_mirror_high: assert property (@(posedge clk) disable iff (!rst_n)
    btn_i |=> pbtn_o);

  a_r9_mirror_low: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_i |=> !pbtn_o);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_evt_o |=> !sleep_evt_o);
endmodule

bind pbsc_supply_ctrl pbsc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .btn_i       (btn_i),
  .sw_off_i    (sw_off_i),
  .pwr_ok_i    (pwr_ok_i),
  .supply_on_o (supply_on_o),
  .pbtn_o      (pbtn_o),
  .sleep_evt_o (sleep_evt_o),
  .st          (state_q),
  .fire        (ovr_fire),
  .lock        (ovr_lock),
  .expire      (cb_expire)
);

// File: tb/pbsc_supply_ctrl_test.sv
module pbsc_supply_ctrl_test;
  localparam int HOLD = 20;
  localparam int TPS  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       btn = 1'b0, slp = 1'b0, wake = 1'b0, son = 1'b0, soff = 1'b0, ok = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       supply, pbtn, sevt;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  pbsc_supply_ctrl #(.HOLD_TICKS(HOLD), .TICKS_PER_SEC(TPS), .CB_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_i(btn), .sleep_btn_i(slp),
    .wake_req_i(wake), .sw_on_i(son), .sw_off_i(soff), .pwr_ok_i(ok),
    .crowbar_sel_i(sel), .supply_on_o(supply), .pbtn_o(pbtn), .sleep_evt_o(sevt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Phase model: 0 off, 1 ramp, 2 confirmed on (crowbar disabled, no override).
  function automatic int model_next(input int st, input logic press, input logic wk,
                                    input logic on_c, input logic off_c, input logic good);
    case (st)
      0: return (press || wk || on_c) ? 1 : 0;
      1: return (press || off_c) ? 0 : (good ? 2 : 1);
      default: return (press || off_c) ? 0 : 2;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    step(2);
    chk("R11 supply in reset", supply, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R11 supply after reset", supply, 1'b0);
    chk("R11 pbtn after reset", pbtn, 1'b0);
    chk("R11 sleep evt after reset", sevt, 1'b0);

    // R1 press from off, R9 mirror
    btn = 1; step(1);
    chk("R1 press turns on", supply, 1'b1);
    chk("R9 mirror high", pbtn, 1'b1);
    btn = 0; step(1);
    chk("R9 mirror low", pbtn, 1'b0);
    chk("R1 stays on after release", supply, 1'b1);
    ok = 1; step(1); ok = 0;
    // R2 press while confirmed on
    btn = 1; step(1);
    chk("R2 press turns off", supply, 1'b0);
    btn = 0; step(1);

    // R5 wake, R6 software commands
    wake = 1; step(1); wake = 0;
    chk("R5 wake turns on", supply, 1'b1);
    son = 1; step(1); son = 0;
    chk("R6 sw on ignored while on", supply, 1'b1);
    soff = 1; step(1); soff = 0;
    chk("R6 sw off turns off", supply, 1'b0);
    soff = 1; step(1); soff = 0;
    chk("R6 sw off ignored while off", supply, 1'b0);
    son = 1; step(1); son = 0;
    chk("R6 sw on turns on", supply, 1'b1);
    btn = 1; step(1);
    chk("R2 press during ramp turns off", supply, 1'b0);
    btn = 0; step(1);

    // R8 crowbar: 2 s x 5 ticks = 10 ticks after entering the ramp
    sel = 4'd2;
    son = 1; step(1); son = 0;
    step(9);
    chk("R8 still on before limit", supply, 1'b1);
    step(1);
    chk("R8 dropped at limit", supply, 1'b0);
    sel = 4'd0;
    son = 1; step(1); son = 0;
    step(40);
    chk("R8 zero limit never expires", supply, 1'b1);
    soff = 1; step(1); soff = 0;
    chk("R6 sw off after long ramp", supply, 1'b0);

    // R7 confirmation cancels the crowbar
    sel = 4'd2;
    son = 1; step(1); son = 0;
    step(3);
    ok = 1; step(1); ok = 0;
    step(20);
    chk("R7 confirmed supply survives limit", supply, 1'b1);
    soff = 1; step(1); soff = 0;
    chk("R7 off after confirm", supply, 1'b0);
    sel = 4'd0;

    // R3 override with wake pending in the same cycle
    btn = 1; step(1);
    chk("R3 press turned on", supply, 1'b1);
    step(18);
    chk("R3 on one tick before override", supply, 1'b1);
    wake = 1; step(1); wake = 0;
    chk("R3 override forces off", supply, 1'b0);
    // R4 lockout while held
    son = 1; step(1); son = 0;
    chk("R4 sw on blocked while held", supply, 1'b0);
    wake = 1; step(1); wake = 0;
    chk("R4 wake blocked while held", supply, 1'b0);
    step(30);
    chk("R4 still off while held", supply, 1'b0);
    btn = 0; step(2);
    btn = 1; step(1);
    chk("R4 press after release accepted", supply, 1'b1);
    btn = 0; step(1);
    soff = 1; step(1); soff = 0;

    // R12 no ticks, no override
    tick = 0;
    btn = 1; step(1);
    chk("R12 press on without ticks", supply, 1'b1);
    step(30);
    chk("R12 no override without ticks", supply, 1'b1);
    tick = 1;
    step(19);
    chk("R12 ticks resume, not yet", supply, 1'b1);
    step(1);
    chk("R12 override after ticks", supply, 1'b0);
    btn = 0; step(2);

    // R10 sleep event
    slp = 1; step(1);
    chk("R10 sleep pulse", sevt, 1'b1);
    step(1);
    chk("R10 pulse is single", sevt, 1'b0);
    slp = 0; step(1);
    chk("R10 no pulse on release", sevt, 1'b0);
    slp = 1; step(1);
    chk("R10 second press pulses", sevt, 1'b1);
    slp = 0; step(1);

    // Random phase against the model
    begin
      int st_m = 0;
      int run = 0;
      logic prev = 1'b0;
      for (int i = 0; i < 400; i++) begin
        btn  = (run >= 8) ? 1'b0 : ($urandom % 4 == 0);
        run  = btn ? run + 1 : 0;
        wake = ($urandom % 16 == 0);
        son  = ($urandom % 16 == 0);
        soff = ($urandom % 12 == 0);
        ok   = ($urandom % 6 == 0);
        st_m = model_next(st_m, btn & ~prev, wake, son, soff, ok);
        prev = btn;
        step(1);
        chk("R1 R2 R5 R6 R7 random supply", supply, (st_m != 0));
        chk("R9 random mirror", pbtn, prev);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule